// File: doc/BRIEF.md
# Core-Rail-Low Monitoring Supervisor

This supervisor sits beside a thermal and fan controller that is powered from an always-on standby supply, while the processor core rail may collapse during sleep states. Each digitized core-rail reading is compared against a programmable low limit. When the rail is found low, the supervisor sets a sticky status flag and, if alerts are enabled, pulls an active-low alert line. At the same time it suspends three controller functions that would misbehave on a sleeping processor: it freezes the over-temperature duration timer and stops pin monitoring, it stops automatic adjustment of the minimum-temperature threshold, and it vetoes entry to shutdown.

The suppression is released on its own once the rail climbs back out of a small hysteresis band above the limit. The status flag stays set until the host clears it with a write-one-to-clear strobe. Low-rail handling as a whole depends on a configuration enable. The ADC, the duration timer and the register bus are outside the block and only their signals appear as ports.

Top module: `corerail_low_sup`

## Requirements
- R1: With low-rail handling enabled, a valid sample strictly below the limit puts the block in the low state at the next clock edge. A sample equal to the limit does not.
- R2: Once low, the block leaves the low state only on a valid sample at or above limit + 2. Samples from limit to limit + 1 keep it low. The sum is formed without wrap-around, so a limit of 254 or 255 is never released by a sample.
- R3: A sample with rail_vld_i low changes nothing.
- R4: When lowrail_en_i is 0, the low state is cleared at the next edge and no sample can set it or the status flag.
- R5: ot_hold_o, tmin_freeze_o and shdn_veto_o are 1 exactly while the block is in the low state. All three fall at the edge where the low state is left.
- R6: stat_o is set at the same edge at which the low state is entered. It stays 1 for as long as the low state lasts, and stat_clr_i has no effect during that time.
- R7: After the low state ends, stat_o stays at 1 until stat_clr_i is sampled high, and then reads 0 from the next edge.
- R8: alert_no is 0 exactly when stat_o is 1 and alert_en_i is 1. It follows alert_en_i in the same cycle.
- R9: While rst_ni is low and after reset, stat_o and all suppression outputs are 0 and alert_no is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rail_smp_i | input | SMP_W | Digitized core-rail reading |
| rail_vld_i | input | 1 | Reading on rail_smp_i is valid this cycle |
| low_lim_i | input | SMP_W | Programmed low limit |
| lowrail_en_i | input | 1 | Enables low-rail handling |
| alert_en_i | input | 1 | Enables the alert output |
| stat_clr_i | input | 1 | Write-one-to-clear strobe for the status flag |
| stat_o | output | 1 | Sticky rail-low status flag |
| alert_no | output | 1 | Alert, active low |
| ot_hold_o | output | 1 | Freezes the over-temperature duration timer and stops pin monitoring |
| tmin_freeze_o | output | 1 | Stops automatic minimum-temperature adjustment |
| shdn_veto_o | output | 1 | Blocks entry to shutdown |

## Verification
A wrong low state shows on all three suppression outputs at the first edge after the offending sample, so a comparator or hysteresis error is visible within one cycle of crossing a threshold. A bad status register shows up as a stuck or missing stat_o one edge after a sample or a clear strobe. The bench sweeps the full sample range in both directions across limits at both ends of the code range and in the middle, and compares every output each cycle against a model built from the requirements.

// File: rtl/lowrail_pkg.sv
package lowrail_pkg;
  typedef struct packed {
    logic ot_hold;
    logic tmin_freeze;
    logic shdn_veto;
  } supp_t;

  localparam int unsigned SUPP_N = 3;
endpackage

// File: rtl/lowrail_det.sv
module lowrail_det #(
  parameter int unsigned SMP_W = 8,
  parameter int unsigned HYST  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SMP_W-1:0] smp_i,
  input  logic             vld_i,
  input  logic [SMP_W-1:0] lim_i,
  input  logic             en_i,
  output logic             low_d_o,
  output logic             low_q_o
);
  localparam int unsigned CMP_W = SMP_W + 1;

  logic [CMP_W-1:0] rel_thr;
  logic             below, recovered;
  logic             low_d, low_q;

  // release threshold kept one bit wider so it never wraps
  assign rel_thr   = {1'b0, lim_i} + CMP_W'(HYST);
  assign below     = smp_i < lim_i;
  assign recovered = {1'b0, smp_i} >= rel_thr;

  always_comb begin
    if (!en_i)       low_d = 1'b0;
    else if (!vld_i) low_d = low_q;
    else if (low_q)  low_d = !recovered;
    else             low_d = below;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) low_q <= 1'b0;
    else         low_q <= low_d;
  end

  assign low_d_o = low_d;
  assign low_q_o = low_q;

  a_r1_enter_below: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && vld_i && (smp_i < lim_i)) |=> low_q);
  a_r2_band_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && vld_i && low_q && ({1'b0, smp_i} < ({1'b0, lim_i} + CMP_W'(HYST)))) |=> low_q);
  a_r3_invalid_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !vld_i) |=> $stable(low_q));
  a_r4_disabled_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !low_q);
endmodule

// File: rtl/lowrail_stat.sv
module lowrail_stat (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic alert_en_i,
  output logic stat_o,
  output logic alert_no
);
  logic stat_q;

  // set dominates the clear strobe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= 1'b0;
    else         stat_q <= set_i | (stat_q & ~clr_i);
  end

  assign stat_o   = stat_q;
  assign alert_no = ~(stat_q & alert_en_i);

  a_r7_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q && !clr_i) |=> stat_q);
  a_r7_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !stat_q);
endmodule

// File: rtl/lowrail_supp.sv
module lowrail_supp
  import lowrail_pkg::*;
(
  input  logic  low_i,
  output supp_t supp_o
);
  logic [SUPP_N-1:0] vec;

  for (genvar g = 0; g < SUPP_N; g++) begin : g_supp
    assign vec[g] = low_i;
  end

  assign supp_o = supp_t'(vec);
endmodule

// File: rtl/corerail_low_sup.sv
module corerail_low_sup
  import lowrail_pkg::*;
#(
  parameter int unsigned SMP_W = 8,
  parameter int unsigned HYST  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SMP_W-1:0] rail_smp_i,
  input  logic             rail_vld_i,
  input  logic [SMP_W-1:0] low_lim_i,
  input  logic             lowrail_en_i,
  input  logic             alert_en_i,
  input  logic             stat_clr_i,
  output logic             stat_o,
  output logic             alert_no,
  output logic             ot_hold_o,
  output logic             tmin_freeze_o,
  output logic             shdn_veto_o
);
  logic  low_d, low_q;
  supp_t supp;

  lowrail_det #(.SMP_W(SMP_W), .HYST(HYST)) u_det (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .smp_i   (rail_smp_i),
    .vld_i   (rail_vld_i),
    .lim_i   (low_lim_i),
    .en_i    (lowrail_en_i),
    .low_d_o (low_d),
    .low_q_o (low_q)
  );

  lowrail_stat u_stat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (low_d),
    .clr_i      (stat_clr_i),
    .alert_en_i (alert_en_i),
    .stat_o     (stat_o),
    .alert_no   (alert_no)
  );

  lowrail_supp u_supp (
    .low_i  (low_q),
    .supp_o (supp)
  );

  assign ot_hold_o     = supp.ot_hold;
  assign tmin_freeze_o = supp.tmin_freeze;
  assign shdn_veto_o   = supp.shdn_veto;

  a_r6_stat_covers_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_q |-> stat_o);
  a_r5_release_on_recover: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ot_hold_o) |-> !$past(low_d));
endmodule

// File: tb/corerail_low_sup_tb_top.sv
module corerail_low_sup_tb_top;
  localparam int SMP_W = 8;
  localparam int HYST  = 2;
  localparam int MAXV  = (1 << SMP_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [SMP_W-1:0] smp = '0;
  logic             vld = 1'b0;
  logic [SMP_W-1:0] lim = '0;
  logic             en = 1'b0;
  logic             aen = 1'b0;
  logic             clr = 1'b0;
  logic             stat, alert_n, hold, tfrz, veto;

  int n_chk = 0;
  int n_err = 0;
  bit m_low = 1'b0;
  bit m_stat = 1'b0;

  always #10 clk = ~clk;

  corerail_low_sup #(.SMP_W(SMP_W), .HYST(HYST)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rail_smp_i(smp), .rail_vld_i(vld),
    .low_lim_i(lim), .lowrail_en_i(en), .alert_en_i(aen), .stat_clr_i(clr),
    .stat_o(stat), .alert_no(alert_n), .ot_hold_o(hold),
    .tmin_freeze_o(tfrz), .shdn_veto_o(veto)
  );

  task automatic chk(string req, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%b expected=%b (smp=%0d lim=%0d)", req, what, act, exp, smp, lim);
    end
  endtask

  task automatic check_all(string req_low);
    chk(req_low, "ot_hold", hold, m_low);
    chk("R5", "tmin_freeze", tfrz, m_low);
    chk("R5", "shdn_veto", veto, m_low);
    chk("R6", "stat", stat, m_stat);
    chk("R8", "alert_n", alert_n, !(m_stat && aen));
  endtask

  // inputs set at negedge, model updated at posedge, outputs checked at next negedge
  task automatic step(string req_low, int s, bit v, bit e, bit ae, bit c);
    smp = SMP_W'(s); vld = v; en = e; aen = ae; clr = c;
    @(posedge clk);
    if (!en) m_low = 1'b0;
    else if (vld) m_low = m_low ? (int'(smp) < int'(lim) + HYST) : (int'(smp) < int'(lim));
    m_stat = m_low || (m_stat && !clr);
    @(negedge clk);
    check_all(req_low);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    int lims[6] = '{0, 1, 37, 128, 254, 255};
    #5;
    chk("R9", "stat in reset", stat, 1'b0);
    chk("R9", "hold in reset", hold, 1'b0);
    chk("R9", "alert_n in reset", alert_n, 1'b1);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R9");

    // R2 sweep: down then up across each limit
    foreach (lims[i]) begin
      lim = SMP_W'(lims[i]);
      for (int s = MAXV; s >= 0; s--) step("R2", s, 1, 1, 1, 0);
      for (int s = 0; s <= MAXV; s++) step("R2", s, 1, 1, 1, 0);
      step("R7", MAXV, 1, 1, 1, 1);
      step("R7", MAXV, 1, 0, 1, 0);
      step("R4", 0, 0, 0, 1, 0);
    end

    // R1 exact boundary
    lim = 8'd100;
    step("R1", 100, 1, 1, 1, 0);
    chk("R1", "equal not low", hold, 1'b0);
    step("R1", 99, 1, 1, 1, 0);
    chk("R1", "below is low", hold, 1'b1);
    // R2 band edges
    step("R2", 101, 1, 1, 1, 0);
    chk("R2", "band holds", hold, 1'b1);
    step("R2", 102, 1, 1, 1, 0);
    chk("R2", "release at lim+2", hold, 1'b0);

    // R6 clear has no effect while low, R7 clears after recovery
    step("R6", 50, 1, 1, 1, 1);
    chk("R6", "clr while low", stat, 1'b1);
    step("R7", 200, 1, 1, 1, 0);
    chk("R7", "sticky after recover", stat, 1'b1);
    step("R7", 200, 1, 1, 1, 0);
    step("R7", 200, 1, 1, 1, 1);
    chk("R7", "cleared", stat, 1'b0);

    // R3 invalid samples ignored
    for (int s = 0; s < 100; s += 7) step("R3", s, 0, 1, 1, 0);
    chk("R3", "invalid low sample", hold, 1'b0);
    step("R3", 10, 1, 1, 1, 0);
    for (int s = 255; s > 100; s -= 9) step("R3", s, 0, 1, 1, 0);
    chk("R3", "invalid high sample", hold, 1'b1);

    // R4 disable clears low state and blocks new status
    step("R4", 10, 1, 0, 1, 1);
    chk("R4", "disable clears", hold, 1'b0);
    step("R4", 10, 1, 0, 1, 1);
    for (int s = 0; s < 100; s += 5) step("R4", s, 1, 0, 1, 0);
    chk("R4", "no status when off", stat, 1'b0);

    // R8 alert follows enable
    step("R8", 5, 1, 1, 0, 0);
    chk("R8", "masked", alert_n, 1'b1);
    aen = 1'b1; #1;
    chk("R8", "comb enable", alert_n, 1'b0);
    step("R8", 5, 1, 1, 1, 0);
    aen = 1'b0; #1;
    chk("R8", "comb disable", alert_n, 1'b1);
    step("R8", 200, 1, 1, 1, 1);
    step("R8", 200, 1, 1, 1, 0);
    chk("R8", "deassert after clear", alert_n, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule